// File: doc/BRIEF.md
# Polled Tamper Edge Event Counter

This block watches one tamper input, typically a normally closed switch between the pin and chassis ground, without holding a pull-up on the pin all the time. A slow strobe derived from the real-time-clock oscillator arrives every 125 ms. On each strobe, when polled operation is allowed, the block drives a pull-up enable output for a fixed number of fast clock cycles so the pin can settle. In the last of those cycles it latches the pin. An open switch reads high and a closed switch reads low.

The latched value is compared with the one from the previous poll. A low-to-high change counts as one tamper event and adds one to a wrapping event counter. Polled operation is permitted in one configuration only: the edge-polarity bit must select rising edges, the counter must be in battery-backed mode, and the oscillator must be running. If any of these fails, no pull-up is driven and the count holds. The control bits are set through a byte-wide register write port.

Top module: `tamper_poll_counter`

## Requirements
- R1: After reset the event count is 0, the pull-up enable is low, and all control bits are 0.
- R2: A write to address 0Dh loads the control register. Bit 0 is the edge-polarity bit (1 selects rising edges), bit 1 is the poll enable, and bit 2 is the nonvolatile-mode bit (0 selects battery-backed mode). A write to any other address changes nothing.
- R3: Polling is active only when poll enable is 1, polarity is 1, nonvolatile mode is 0 and the oscillator enable input is 1. While polling is inactive, strobes produce no pull-up and the count does not change.
- R4: A strobe that arrives while polling is active and no poll is in progress raises the pull-up enable for exactly SETTLE_CYCLES cycles, starting on the cycle after the strobe.
- R5: The pin is latched at the clock edge that ends the last pull-up cycle. The count rises by one at that edge only when the previous sample was 0 and this sample is 1.
- R6: The first sample taken after polling becomes active only sets the reference value and never counts.
- R7: A strobe that arrives while a poll is in progress is ignored. It neither lengthens nor restarts the pull-up window.
- R8: The count is COUNT_W bits wide (16 by default) and wraps from its maximum value to 0.
- R9: If polling becomes inactive during a poll, the pull-up enable drops in that same cycle and no sample is taken.
- R10: A control write that lands in the sampling cycle takes effect only after that edge, so that sample is still taken and counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | One-cycle 125 ms poll strobe from the RTC divider |
| osc_en | input | 1 | RTC oscillator running |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pin_in | input | 1 | Tamper pin level |
| pullup_en | output | 1 | Internal pull-up enable for the pin |
| event_count | output | COUNT_W | Tamper event count |

## Verification
Two functions can fall in the same cycle: a control write that disables polling, and the latching of a sample at the end of a pull-up window. The bench provokes this by running a poll with the pin low and then a poll with the pin high. It issues the disabling write so that it is captured by the same edge that latches the high sample. The bench then expects the count to rise by one, and it expects the next strobe to produce no pull-up. A second overlap is a strobe that arrives inside a pull-up window. The bench judges it by checking that the window stays exactly SETTLE_CYCLES long.

// File: rtl/tp_pkg.sv
package tp_pkg;

  localparam logic [7:0] CTRL_ADDR = 8'h0D;

  typedef struct packed {
    logic nv_mode;
    logic poll_on;
    logic rise_pol;
  } tp_ctrl_t;

  typedef enum logic [0:0] {
    SEQ_IDLE   = 1'b0,
    SEQ_SETTLE = 1'b1
  } tp_seq_e;

  function automatic logic cfg_ok(input tp_ctrl_t c, input logic osc);
    return c.poll_on & c.rise_pol & ~c.nv_mode & osc;
  endfunction

  function automatic logic is_rise(input logic ref_ok, input logic prev, input logic now);
    return ref_ok & ~prev & now;
  endfunction

  function automatic tp_ctrl_t unpack_ctrl(input logic [7:0] d);
    tp_ctrl_t c;
    c.rise_pol = d[0];
    c.poll_on  = d[1];
    c.nv_mode  = d[2];
    return c;
  endfunction

endpackage

// File: rtl/tp_ctrl_reg.sv
module tp_ctrl_reg
  import tp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output tp_ctrl_t   ctrl
);

  logic hit;
  assign hit = wr_en && (wr_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (hit) begin
      ctrl <= unpack_ctrl(wr_data);
    end
  end

endmodule

// File: rtl/tp_poll_seq.sv
module tp_poll_seq
  import tp_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rtc_tick,
  output logic pullup_en,
  output logic sample_strobe
);

  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  tp_seq_e       state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else if (!active) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          cnt <= '0;
          if (rtc_tick) state <= SEQ_SETTLE;
        end
        SEQ_SETTLE: begin
          if (cnt == LAST) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign pullup_en     = (state == SEQ_SETTLE) && active;
  assign sample_strobe = pullup_en && (cnt == LAST);

endmodule

// File: rtl/tp_edge_count.sv
module tp_edge_count
  import tp_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               sample_strobe,
  input  logic               pin_in,
  output logic               rise_seen,
  output logic [COUNT_W-1:0] count
);

  logic prev;
  logic ref_ok;

  assign rise_seen = sample_strobe && is_rise(ref_ok, prev, pin_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      ref_ok <= 1'b0;
    end else if (!active) begin
      ref_ok <= 1'b0;
    end else if (sample_strobe) begin
      prev   <= pin_in;
      ref_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (rise_seen) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/tamper_poll_counter.sv
module tamper_poll_counter
  import tp_pkg::*;
#(
  parameter int COUNT_W       = 16,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rtc_tick,
  input  logic               osc_en,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               pin_in,
  output logic               pullup_en,
  output logic [COUNT_W-1:0] event_count
);

  tp_ctrl_t ctrl;
  logic     poll_active;
  logic     sample_strobe;
  logic     rise_seen;

  tp_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  assign poll_active = cfg_ok(ctrl, osc_en);

  tp_poll_seq #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (poll_active),
    .rtc_tick      (rtc_tick),
    .pullup_en     (pullup_en),
    .sample_strobe (sample_strobe)
  );

  tp_edge_count #(.COUNT_W(COUNT_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .active        (poll_active),
    .sample_strobe (sample_strobe),
    .pin_in        (pin_in),
    .rise_seen     (rise_seen),
    .count         (event_count)
  );

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rtc_tick,
  input logic               osc_en,
  input logic               pullup_en,
  input logic               poll_active,
  input logic               sample_strobe,
  input logic               rise_seen,
  input logic [COUNT_W-1:0] event_count
);

  p_pullup_needs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_en |-> (poll_active && osc_en));

  p_window_opens_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pullup_en) |-> $past(rtc_tick));

  p_strobe_inside_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> pullup_en);

  p_count_moves_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(event_count) |-> $past(rise_seen) && $past(sample_strobe));

  p_count_steps_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(event_count) |-> event_count == COUNT_W'($past(event_count) + 1'b1));

  p_window_closes_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !pullup_en);

endmodule

bind tamper_poll_counter tp_checker #(.COUNT_W(COUNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rtc_tick      (rtc_tick),
  .osc_en        (osc_en),
  .pullup_en     (pullup_en),
  .poll_active   (poll_active),
  .sample_strobe (sample_strobe),
  .rise_seen     (rise_seen),
  .event_count   (event_count)
);

// File: tb/tamper_poll_counter_tb.sv
module tamper_poll_counter_tb;

  localparam int CW = 4;
  localparam int ST = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rtc_tick = 1'b0;
  logic          osc_en = 1'b1;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = 8'h00;
  logic [7:0]    wr_data = 8'h00;
  logic          pin_in = 1'b1;
  logic          pullup_en;
  logic [CW-1:0] event_count;

  int n_chk = 0;
  int n_bad = 0;
  logic [CW-1:0] exp_cnt = '0;
  logic m_prev = 1'b0;
  logic m_ok = 1'b0;

  always #5 clk = ~clk;

  tamper_poll_counter #(.COUNT_W(CW), .SETTLE_CYCLES(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .osc_en(osc_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pin_in(pin_in),
    .pullup_en(pullup_en), .event_count(event_count)
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic model_ok(input logic [7:0] d, input logic osc);
    return (d[1] == 1'b1) && (d[0] == 1'b1) && (d[2] == 1'b0) && osc;
  endfunction

  // Runs one poll; checks the pull-up window and updates the model.
  task automatic poll(input logic v, input logic expect_on, input string req);
    int hi;
    @(negedge clk); pin_in = v; rtc_tick = 1'b1;
    @(negedge clk); rtc_tick = 1'b0;
    hi = 0;
    for (int i = 0; i < ST + 2; i++) begin
      if (pullup_en) hi++;
      if (i == 1) begin rtc_tick = 1'b1; end
      else rtc_tick = 1'b0;
      @(negedge clk);
    end
    rtc_tick = 1'b0;
    check(req, hi, expect_on ? ST : 0);
    if (expect_on) begin
      if (m_ok && !m_prev && v) exp_cnt = exp_cnt + 1'b1;
      m_prev = v; m_ok = 1'b1;
    end
    check(req, event_count, exp_cnt);
  endtask

  initial begin
    #200000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", event_count, 0);
    check("R1 pullup", pullup_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    poll(1'b0, 1'b0, "R1 ctrl zero gives no poll");

    // R2 wrong address ignored
    wr(8'h0C, 8'h03);
    poll(1'b0, 1'b0, "R2 other address");

    // R2/R3 sweep all control combos with osc on and off
    for (int o = 0; o < 2; o++) begin
      for (int c = 0; c < 8; c++) begin
        logic on;
        osc_en = o[0];
        wr(8'h0D, 8'(c));
        on = model_ok(8'(c), o[0]);
        m_ok = 1'b0;
        poll(1'b0, on, "R3 cfg sweep low");
        poll(1'b1, on, "R3 cfg sweep high");
      end
    end
    osc_en = 1'b1;

    // R5/R6 exhaustive 5-sample patterns, fresh reference each time
    for (int p = 0; p < 32; p++) begin
      wr(8'h0D, 8'h00); m_ok = 1'b0;
      wr(8'h0D, 8'h03);
      for (int b = 0; b < 5; b++) poll(p[b], 1'b1, "R5 R6 pattern");
    end

    // R7: extra strobe inside window is covered by poll() (window stays ST)
    poll(1'b0, 1'b1, "R7 tick in window");

    // R8 wrap: drive rising edges until count wraps past max
    while (exp_cnt != '1) begin
      poll(1'b0, 1'b1, "R8 climb");
      poll(1'b1, 1'b1, "R8 climb");
    end
    check("R8 at max", event_count, (1 << CW) - 1);
    poll(1'b0, 1'b1, "R8 wrap");
    poll(1'b1, 1'b1, "R8 wrap");
    check("R8 wrapped to zero", event_count, 0);

    // R9 abort: drop osc mid window
    poll(1'b0, 1'b1, "R9 setup");
    @(negedge clk); pin_in = 1'b1; rtc_tick = 1'b1;
    @(negedge clk); rtc_tick = 1'b0;
    check("R9 window open", pullup_en, 1);
    osc_en = 1'b0; #1;
    check("R9 pullup drops same cycle", pullup_en, 0);
    repeat (ST + 2) @(negedge clk);
    check("R9 no sample counted", event_count, exp_cnt);
    osc_en = 1'b1; m_ok = 1'b0;
    poll(1'b1, 1'b1, "R9 reseed after abort");
    check("R6 reseed no count", event_count, exp_cnt);

    // R10 write in sampling cycle
    poll(1'b0, 1'b1, "R10 setup");
    @(negedge clk); pin_in = 1'b1; rtc_tick = 1'b1;
    @(negedge clk); rtc_tick = 1'b0;
    repeat (ST - 1) @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h0D; wr_data = 8'h00;
    @(negedge clk); wr_en = 1'b0;
    exp_cnt = exp_cnt + 1'b1;
    check("R10 sample still counted", event_count, exp_cnt);
    m_ok = 1'b0;
    poll(1'b0, 1'b0, "R10 disabled afterwards");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule